// File: doc/BRIEF.md
# Rank Clock-Enable Idle Power-Down Controller

This block owns the clock-enable line of every DRAM rank. For each rank it counts consecutive clocks with no command activity. When the count reaches a programmed threshold it drops that rank's clock enable, which puts the rank into low-power mode. The threshold is one of four fixed values, widely spaced, that do not depend on clock frequency.

When the scheduler marks a command as pending for a rank that is powered down, the block raises clock enable on the next clock. It then keeps a per-rank hold line asserted toward the scheduler for a guard band of one or two clocks, so the command cannot be granted before the rank is ready. A pending command to a rank that is already awake is never delayed.

A configuration change does not cut short an idle count that is already running. Each rank captures the threshold when its count restarts, and captures the guard length when it begins to wake.

Top module: `cke_pd_ctrl`

## Requirements
- R1: While reset is asserted and directly after it is released, every `rank_cke` bit is 1 and every `rank_hold` bit is 0.
- R2: The idle threshold is selected by `cfg_idle_sel`: 00 gives 32, 01 gives 128, 10 gives 512 and 11 gives 2048. An awake rank drops `rank_cke` on exactly the clock edge that completes that number of consecutive idle clock edges, and never earlier.
- R3: A cycle with `rank_pend` or `rank_issued` high on an awake rank restarts that rank's idle count from zero. The idle counts of the other ranks are not affected.
- R4: While `rank_pend` stays high on an awake rank, that rank never powers down and its `rank_hold` stays 0, so the command is granted with no added delay.
- R5: When `rank_pend` is high for a rank whose `rank_cke` is 0, `rank_cke` becomes 1 on the next clock edge and `rank_hold` stays 1 on that edge.
- R6: If `cfg_guard2` is 0 when the wake starts, `rank_hold` falls one clock edge after `rank_cke` rises.
- R7: If `cfg_guard2` is 1 when the wake starts, `rank_hold` stays 1 for the clock edge after `rank_cke` rises and falls on the edge after that.
- R8: A change to `cfg_idle_sel` while an idle count is running does not alter that count. The new threshold applies from the next restart of the count, which can be caused by activity or by the end of a wake.
- R9: `rank_hold` is 1 whenever `rank_cke` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle_sel | input | 2 | Idle threshold select (32/128/512/2048) |
| cfg_guard2 | input | 1 | 0: one-clock guard, 1: two-clock guard |
| rank_pend | input | NUM_RANKS | Command pending per rank |
| rank_issued | input | NUM_RANKS | Command issued per rank |
| rank_cke | output | NUM_RANKS | Clock enable per rank |
| rank_hold | output | NUM_RANKS | Grant hold toward the scheduler per rank |

## Verification
The bound checker watches several rules on every cycle: that a rank which is down is always held (R9), that a pending command wakes a down rank on the next edge (R5), and that the hold lasts for the guard length latched at the rise of clock enable (R6, R7). Using its own run counter, it also confirms that no rank powers down with activity present or before the shortest threshold has passed (R2, R4). The exact threshold for each encoding, the restart of the count by a mid-count issue, the independence of the ranks, and the deferred effect of a configuration change (R2, R3, R8) depend on long histories. Only the bench's directed scenarios show those, by counting edges up to the expected power-down.

// File: rtl/cke_pkg.sv
package cke_pkg;
  localparam int IDLE_CW   = 12;
  localparam int IDLE_BASE = 32;
  localparam int GUARD_W   = 2;

  typedef enum logic [1:0] {
    ST_UP   = 2'd0,
    ST_DOWN = 2'd1,
    ST_WAKE = 2'd2
  } rank_st_e;

  // Threshold quadruples for each step of the select field
  function automatic logic [IDLE_CW-1:0] idle_limit(input logic [1:0] sel);
    return IDLE_CW'(IDLE_BASE) << (2 * sel);
  endfunction

  // Guard length in clocks of high clock enable before release
  function automatic logic [GUARD_W-1:0] guard_len(input logic two);
    return two ? GUARD_W'(2) : GUARD_W'(1);
  endfunction

  function automatic logic [IDLE_CW-1:0] cnt_inc(input logic [IDLE_CW-1:0] v);
    return v + IDLE_CW'(1);
  endfunction
endpackage

// File: rtl/cke_idle_timer.sv
module cke_idle_timer
  import cke_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       hit
);
  logic [IDLE_CW-1:0] cnt_q;
  logic [IDLE_CW-1:0] lim_q;
  logic               at_lim;

  assign at_lim = (cnt_q == lim_q);

  // The limit is captured only on a restart, so a running count is never cut short
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= idle_limit(2'b00);
    end else if (clr) begin
      cnt_q <= '0;
      lim_q <= idle_limit(sel);
    end else if (run && !at_lim) begin
      cnt_q <= cnt_inc(cnt_q);
    end
  end

  assign hit = run && !clr && (cnt_inc(cnt_q) == lim_q);
endmodule

// File: rtl/cke_rank_ctl.sv
module cke_rank_ctl
  import cke_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend,
  input  logic       issued,
  input  logic [1:0] idle_sel,
  input  logic       guard2,
  output logic       cke,
  output logic       hold,
  output logic       idle_hit
);
  rank_st_e           st_q;
  logic [GUARD_W-1:0] gcnt_q;
  logic [GUARD_W-1:0] glen_q;
  logic               awake;
  logic               waking;
  logic               tmr_clr;
  logic               guard_done;

  assign awake      = (st_q == ST_UP);
  assign waking     = (st_q == ST_WAKE);
  assign tmr_clr    = (awake && (pend || issued)) || waking;
  assign guard_done = ((gcnt_q + GUARD_W'(1)) == glen_q);

  cke_idle_timer u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (awake),
    .sel   (idle_sel),
    .hit   (idle_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_UP;
      gcnt_q <= '0;
      glen_q <= guard_len(1'b0);
    end else begin
      unique case (st_q)
        ST_UP: begin
          if (idle_hit) st_q <= ST_DOWN;
        end
        ST_DOWN: begin
          if (pend) begin
            st_q   <= ST_WAKE;
            gcnt_q <= '0;
            glen_q <= guard_len(guard2);
          end
        end
        ST_WAKE: begin
          if (guard_done) st_q <= ST_UP;
          else            gcnt_q <= gcnt_q + GUARD_W'(1);
        end
        default: st_q <= ST_UP;
      endcase
    end
  end

  assign cke  = (st_q != ST_DOWN);
  assign hold = !awake;
endmodule

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl
  import cke_pkg::*;
#(
  parameter int NUM_RANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_idle_sel,
  input  logic                 cfg_guard2,
  input  logic [NUM_RANKS-1:0] rank_pend,
  input  logic [NUM_RANKS-1:0] rank_issued,
  output logic [NUM_RANKS-1:0] rank_cke,
  output logic [NUM_RANKS-1:0] rank_hold
);
  // Per-rank timer expiry, brought out for the checker
  logic [NUM_RANKS-1:0] idle_hit;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    cke_rank_ctl u_rank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (rank_pend[r]),
      .issued   (rank_issued[r]),
      .idle_sel (cfg_idle_sel),
      .guard2   (cfg_guard2),
      .cke      (rank_cke[r]),
      .hold     (rank_hold[r]),
      .idle_hit (idle_hit[r])
    );
  end
endmodule

// File: rtl/cke_pd_ctrl_chk.sv
module cke_pd_ctrl_chk
  import cke_pkg::*;
#(
  parameter int NUM_RANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_guard2,
  input logic [NUM_RANKS-1:0] rank_pend,
  input logic [NUM_RANKS-1:0] rank_issued,
  input logic [NUM_RANKS-1:0] rank_cke,
  input logic [NUM_RANKS-1:0] rank_hold,
  input logic [NUM_RANKS-1:0] idle_hit
);
  localparam logic [IDLE_CW-1:0] MIN_IDLE = idle_limit(2'b00);
  localparam logic [IDLE_CW-1:0] MAX_IDLE = idle_limit(2'b11);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    logic [IDLE_CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        run_q <= '0;
      else if (rank_pend[r] || rank_issued[r] || rank_hold[r] || !rank_cke[r])
        run_q <= '0;
      else if (run_q != MAX_IDLE)
        run_q <= run_q + IDLE_CW'(1);
    end

    a_r9_down_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rank_cke[r] |-> rank_hold[r]);

    a_r5_wake_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!rank_cke[r] && rank_pend[r]) |=> (rank_cke[r] && rank_hold[r]));

    a_r6_guard_one: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rank_cke[r]) && !$past(cfg_guard2)) |=> !rank_hold[r]);

    a_r7_guard_two: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rank_cke[r]) && $past(cfg_guard2)) |=> rank_hold[r]);

    a_r2_min_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rank_cke[r]) |-> (run_q >= MIN_IDLE));

    a_r4_no_sleep_busy: assert property (@(posedge clk) disable iff (!rst_n)
      idle_hit[r] |-> !(rank_pend[r] || rank_issued[r]));
  end
endmodule

bind cke_pd_ctrl cke_pd_ctrl_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (.*);

// File: tb/sim_cke_pd_ctrl.sv
`timescale 1ns/1ps
module sim_cke_pd_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cfg_idle_sel = 2'b00;
  logic         cfg_guard2 = 1'b0;
  logic [N-1:0] rank_pend = '0;
  logic [N-1:0] rank_issued = '0;
  logic [N-1:0] rank_cke;
  logic [N-1:0] rank_hold;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cke_pd_ctrl #(.NUM_RANKS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_idle_sel(cfg_idle_sel), .cfg_guard2(cfg_guard2),
    .rank_pend(rank_pend), .rank_issued(rank_issued),
    .rank_cke(rank_cke), .rank_hold(rank_hold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Threshold for a select code, restated from R2
  function automatic int thr(input logic [1:0] s);
    case (s)
      2'b00: return 32;
      2'b01: return 128;
      2'b10: return 512;
      default: return 2048;
    endcase
  endfunction

  task automatic t_reset();
    rank_pend = 4'b0010;
    tick(3);
    check("R1 cke in reset", rank_cke, 4'hF);
    check("R1 hold in reset", rank_hold, 4'h0);
    rst_n = 1'b1;
    check("R1 cke after release", rank_cke, 4'hF);
    check("R1 hold after release", rank_hold, 4'h0);
  endtask

  // Rank 1 kept pending, rank 2 restarted by an issue at edge 20
  task automatic t_idle_base();
    tick(19);
    rank_issued[2] = 1'b1;
    tick(1);
    rank_issued[2] = 1'b0;
    tick(thr(2'b00) - 21);
    check("R2 rank0 awake at 31", rank_cke[0], 1'b1);
    check("R2 rank3 awake at 31", rank_cke[3], 1'b1);
    tick(1);
    check("R2 rank0 down at 32", rank_cke[0], 1'b0);
    check("R2 rank3 down at 32", rank_cke[3], 1'b0);
    check("R9 rank0 held while down", rank_hold[0], 1'b1);
    check("R4 rank1 pending stays awake", rank_cke[1], 1'b1);
    check("R4 rank1 not held", rank_hold[1], 1'b0);
    check("R3 rank2 still awake", rank_cke[2], 1'b1);
    tick(19);
    check("R3 rank2 awake at 51", rank_cke[2], 1'b1);
    tick(1);
    check("R3 rank2 down at 52", rank_cke[2], 1'b0);
  endtask

  task automatic t_guard_one();
    cfg_guard2 = 1'b0;
    rank_pend[0] = 1'b1;
    tick(1);
    check("R5 rank0 cke rises", rank_cke[0], 1'b1);
    check("R5 rank0 held at rise", rank_hold[0], 1'b1);
    tick(1);
    check("R6 rank0 released after one", rank_hold[0], 1'b0);
  endtask

  task automatic t_guard_two();
    cfg_guard2 = 1'b1;
    rank_pend[3] = 1'b1;
    tick(1);
    check("R5 rank3 cke rises", rank_cke[3], 1'b1);
    check("R7 rank3 held at rise", rank_hold[3], 1'b1);
    tick(1);
    check("R7 rank3 held second clock", rank_hold[3], 1'b1);
    tick(1);
    check("R7 rank3 released after two", rank_hold[3], 1'b0);
    rank_pend[3] = 1'b0;
  endtask

  // Select changes to 11 mid-count: old 32 still applies, 2048 after the wake
  task automatic t_cfg_change();
    rank_pend[0] = 1'b0;
    cfg_idle_sel = 2'b11;
    tick(31);
    check("R8 rank0 awake at 31", rank_cke[0], 1'b1);
    tick(1);
    check("R8 rank0 down at old 32", rank_cke[0], 1'b0);
    rank_pend[0] = 1'b1;
    tick(1);
    check("R5 rank0 rewake", rank_cke[0], 1'b1);
    tick(1);
    check("R7 rank0 held second clock", rank_hold[0], 1'b1);
    tick(1);
    check("R7 rank0 released", rank_hold[0], 1'b0);
    rank_pend[0] = 1'b0;
    tick(thr(2'b11) - 1);
    check("R2 rank0 awake at 2047", rank_cke[0], 1'b1);
    tick(1);
    check("R2 rank0 down at 2048", rank_cke[0], 1'b0);
  endtask

  task automatic t_sel_128();
    cfg_idle_sel = 2'b01;
    tick(1);
    check("R4 rank1 awake long pending", rank_cke[1], 1'b1);
    rank_pend[1] = 1'b0;
    tick(thr(2'b01) - 1);
    check("R2 rank1 awake at 127", rank_cke[1], 1'b1);
    tick(1);
    check("R2 rank1 down at 128", rank_cke[1], 1'b0);
  endtask

  task automatic t_sel_512();
    cfg_idle_sel = 2'b10;
    rank_pend[1] = 1'b1;
    tick(1);
    check("R5 rank1 wake", rank_cke[1], 1'b1);
    tick(2);
    check("R7 rank1 released", rank_hold[1], 1'b0);
    rank_pend[1] = 1'b0;
    tick(200);
    rank_issued[1] = 1'b1;
    tick(1);
    rank_issued[1] = 1'b0;
    tick(thr(2'b10) - 1);
    check("R3 rank1 awake 511 after issue", rank_cke[1], 1'b1);
    tick(1);
    check("R2 rank1 down at 512", rank_cke[1], 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_base();
    t_guard_one();
    t_guard_two();
    t_cfg_change();
    t_sel_128();
    t_sel_512();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule